// File: doc/BRIEF.md
# Keyed watchdog timer with posted register writes

This block is a watchdog for a system bus. A small word-addressed register file runs on the system clock. An up-counter advances only on a slow tick, a single-cycle enable near 32 kHz, and the tick can be divided further by a programmable power-of-two prescaler. Software cannot arm or disarm the counter with one store. It must write two key words to the key register in a fixed order. A trigger register reloads the counter from the load register. If software stops servicing the trigger, the counter passes its all-ones value and the block drives a reset pulse.

Every write to the control, load, trigger and key registers is posted. The value goes into a shadow copy and a pending flag is set in the status register. The value takes effect at the next slow tick, and the flag clears at that same tick. Software polls the flag before it writes the same register again. A write that arrives while the flag for that register is still set is dropped.

Top module: `wdt_keyed`

## Requirements
- R1: Reading word address 0 returns the revision code REV_CODE (default 0x31) in bits 7:0 and zeros above.
- R2: The word addresses are control 1, status 2, load 3, counter 4, trigger 5 and key 6. An accepted write sets its pending bit in the status register: control is bit 0, load bit 2, trigger bit 3 and key bit 4. At the next tick the value takes effect and the pending bit clears.
- R3: A write to a register whose pending bit is still set is ignored and leaves the shadow value unchanged.
- R4: Writing 0xBBBB and then 0x4444 to the key register arms the watchdog. From the tick after the second word applies, the counter (read at address 4) advances.
- R5: Writing 0xAAAA and then 0x5555 to the key register disarms the watchdog. From then on, ticks leave the counter unchanged.
- R6: Any applied key word other than the expected second word discards a half-done sequence. A first word (0xBBBB or 0xAAAA) always starts a new sequence.
- R7: Control bit 5 enables the prescaler and control bits 4:2 hold PTV. When the prescaler is enabled, an armed counter advances once every 2^PTV ticks counted from the last reload. When it is disabled, the counter advances on every tick.
- R8: An applied trigger write reloads the counter from the load register only if its value differs from the previous applied trigger value, which is 0 after reset. A repeated value does not reload.
- R9: A new load value does not change the counter. It is used only at the next reload.
- R10: When an armed counter advances from all ones, the counter wraps to 0 and the block disarms. wd_rst then goes high for exactly RST_CYC clocks, starting with the clock after that tick.
- R11: After reset the block is disarmed, the counter, control and status read 0, and wd_rst is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow-domain enable, one clock wide |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wd_rst | output | 1 | Watchdog reset pulse |

## Verification
The checker assumes three things about the inputs: tick is high for only one clock at a time, each write strobe lasts a single clock, and addresses stay inside the map. Under those conditions a pending flag can clear only on a tick, and the counter can only step by one or jump to a reload value. The stimulus holds tick for exactly one clock with idle clocks around it, drives one-clock write strobes, and always waits for a tick between writes to the same register, except in the one case that tests the dropped second write. Random key words, including values that are not keys, are compared against a bench model of the sequence rules. Random prescale settings are compared against the expected advance period.

// File: rtl/wdt_pkg.sv
// Shared constants for the keyed watchdog: word addresses, key words,
// pending-bit positions and the key sequencer state type.
package wdt_pkg;
    localparam int ADDR_W = 3;
    localparam int PTV_W  = 3;
    localparam int PRE_W  = (1 << PTV_W) - 1;

    localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd6;

    localparam logic [15:0] KEY_ARM_1 = 16'hBBBB;
    localparam logic [15:0] KEY_ARM_2 = 16'h4444;
    localparam logic [15:0] KEY_DIS_1 = 16'hAAAA;
    localparam logic [15:0] KEY_DIS_2 = 16'h5555;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ARM  = 2'd1,
        KS_DIS  = 2'd2
    } key_state_t;
endpackage

// File: rtl/wdt_regif.sv
// Posted register front end. A bus write is taken into a shadow copy and
// sets a pending flag. The copy is applied on the next tick and the flag
// clears. Assumes tick and bus_wr are single-cycle strobes.
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              pre_en,
    output logic [PTV_W-1:0]  ptv,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  load_eff,
    output logic [DATA_W-1:0] trig_q,
    output logic              reload,
    output logic              key_fire,
    output logic [15:0]       key_word,
    output logic [4:0]        pend
);
    logic [PTV_W:0]    sh_ctrl, ctrl_q;
    logic [CNT_W-1:0]  sh_load;
    logic [DATA_W-1:0] sh_trig;
    logic [15:0]       sh_key;
    logic              p_ctrl, p_load, p_trig, p_key;

    // Control: capture when free, apply on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ctrl <= '0; ctrl_q <= '0; p_ctrl <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTRL && !p_ctrl) begin
            sh_ctrl <= bus_wdata[5:2]; p_ctrl <= 1'b1;
        end else if (tick && p_ctrl) begin
            ctrl_q <= sh_ctrl; p_ctrl <= 1'b0;
        end
    end

    // Load: capture when free, apply on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_load <= '0; load_q <= '0; p_load <= 1'b0;
        end else if (bus_wr && bus_addr == A_LOAD && !p_load) begin
            sh_load <= bus_wdata[CNT_W-1:0]; p_load <= 1'b1;
        end else if (tick && p_load) begin
            load_q <= sh_load; p_load <= 1'b0;
        end
    end

    // Trigger: capture when free, remember the applied value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_trig <= '0; trig_q <= '0; p_trig <= 1'b0;
        end else if (bus_wr && bus_addr == A_TRIG && !p_trig) begin
            sh_trig <= bus_wdata; p_trig <= 1'b1;
        end else if (tick && p_trig) begin
            trig_q <= sh_trig; p_trig <= 1'b0;
        end
    end

    // Key: capture when free, hand to the sequencer on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_key <= '0; p_key <= 1'b0;
        end else if (bus_wr && bus_addr == A_KEY && !p_key) begin
            sh_key <= bus_wdata[15:0]; p_key <= 1'b1;
        end else if (tick && p_key) begin
            p_key <= 1'b0;
        end
    end

    // Apply-time strobes and the effective load value for this tick
    always_comb begin
        pre_en   = ctrl_q[PTV_W];
        ptv      = ctrl_q[PTV_W-1:0];
        load_eff = (tick && p_load) ? sh_load : load_q;
        reload   = tick && p_trig && (sh_trig != trig_q);
        key_fire = tick && p_key;
        key_word = sh_key;
        pend     = {p_key, p_trig, p_load, 1'b0, p_ctrl};
    end
endmodule

// File: rtl/wdt_keyseq.sv
// Key sequencer. Watches applied key words and sets or clears the armed
// flag on a complete ordered pair. A counter overflow also disarms.
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_fire,
    input  logic [15:0] key_word,
    input  logic        ovf,
    output logic        armed
);
    key_state_t ks;

    // Sequence state and armed flag; overflow has the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks    <= KS_IDLE;
            armed <= 1'b0;
        end else begin
            if (key_fire) begin
                if (key_word == KEY_ARM_1)      ks <= KS_ARM;
                else if (key_word == KEY_DIS_1) ks <= KS_DIS;
                else                            ks <= KS_IDLE;
                if (ks == KS_ARM && key_word == KEY_ARM_2) armed <= 1'b1;
                if (ks == KS_DIS && key_word == KEY_DIS_2) armed <= 1'b0;
            end
            if (ovf) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
// Prescaler, up-counter and reset pulse stretcher. The counter steps on
// tick while armed, reloads on request, and starts a pulse of RST_CYC
// clocks when it passes all ones.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             armed,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             wd_rst
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic [PRE_W-1:0] pre_cnt, pre_top;
    logic [PRE_W:0]   pre_span;
    logic             adv;
    logic [RC_W-1:0]  rst_cnt;

    // Advance decision for this tick
    always_comb begin
        pre_span = ({{PRE_W{1'b0}}, 1'b1} << ptv) - 1'b1;
        pre_top  = pre_span[PRE_W-1:0];
        adv      = tick && armed && (!pre_en || pre_cnt == pre_top);
        ovf      = adv && (&count) && !reload;
    end

    // Prescaler: cleared by reload or while disarmed
    always_ff @(posedge clk) begin
        if (!rst_n || reload || !armed) pre_cnt <= '0;
        else if (tick && pre_en)        pre_cnt <= (pre_cnt == pre_top) ? '0 : pre_cnt + 1'b1;
    end

    // Main counter: reload wins over advance
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (reload) count <= load_val;
        else if (adv)    count <= count + 1'b1;
    end

    // Reset pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n)             rst_cnt <= '0;
        else if (ovf)           rst_cnt <= RC_W'(RST_CYC);
        else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
    end

    assign wd_rst = (rst_cnt != '0);
endmodule

// File: rtl/wdt_keyed.sv
// Keyed watchdog top. Joins the posted register front end, the key
// sequencer and the counter, and drives the read mux. Assumes a
// synchronous active-low reset and a one-cycle tick enable.
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          DATA_W   = 32,
    parameter int          RST_CYC  = 8,
    parameter logic [7:0]  REV_CODE = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst
);
    logic             pre_en, reload, key_fire, armed, ovf;
    logic [PTV_W-1:0] ptv;
    logic [CNT_W-1:0] load_q, load_eff, count;
    logic [DATA_W-1:0] trig_q;
    logic [15:0]      key_word;
    logic [4:0]       pend;

    wdt_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pre_en(pre_en),
        .ptv(ptv), .load_q(load_q), .load_eff(load_eff), .trig_q(trig_q),
        .reload(reload), .key_fire(key_fire), .key_word(key_word), .pend(pend)
    );

    wdt_keyseq u_keyseq (
        .clk(clk), .rst_n(rst_n), .key_fire(key_fire), .key_word(key_word),
        .ovf(ovf), .armed(armed)
    );

    wdt_counter #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed), .pre_en(pre_en),
        .ptv(ptv), .reload(reload), .load_val(load_eff), .count(count),
        .ovf(ovf), .wd_rst(wd_rst)
    );

    // Read mux over the word map
    always_comb begin
        case (bus_addr)
            A_REV:   bus_rdata = DATA_W'(REV_CODE);
            A_CTRL:  bus_rdata = DATA_W'({pre_en, ptv, 2'b00});
            A_STAT:  bus_rdata = DATA_W'(pend);
            A_LOAD:  bus_rdata = DATA_W'(load_q);
            A_COUNT: bus_rdata = DATA_W'(count);
            A_TRIG:  bus_rdata = trig_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
// Property checker for the keyed watchdog, bound into every instance of
// the top. Assumes tick and write strobes last one clock.
module wdt_keyed_chk #(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [4:0]       pend,
    input logic             armed,
    input logic             key_fire,
    input logic [15:0]      key_word,
    input logic             reload,
    input logic [CNT_W-1:0] count,
    input logic             wd_rst
);
    logic [31:0] hi_len;

    // Length of the current reset pulse so far
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_len <= '0;
        else if (wd_rst) hi_len <= hi_len + 1;
        else             hi_len <= '0;
    end

    AST_PEND_HOLD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !tick) |=> pend[0]); // R2
    AST_PEND_HOLD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[4] && !tick) |=> pend[4]); // R2
    AST_PEND_CLEAR_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[3] && tick) |=> !pend[3]); // R2
    AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_fire && key_word == 16'h4444)); // R4
    AST_CNT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R7
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> (hi_len == RST_CYC)); // R10
    AST_RST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> !armed); // R10
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend), .armed(armed),
    .key_fire(key_fire), .key_word(key_word), .reload(reload),
    .count(count), .wd_rst(wd_rst)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
    localparam int CLK_P   = 10;
    localparam int RST_CYC = 8;
    localparam logic [2:0] AD_REV = 3'd0, AD_CTRL = 3'd1, AD_STAT = 3'd2,
        AD_LOAD = 3'd3, AD_CNT = 3'd4, AD_TRIG = 3'd5, AD_KEY = 3'd6;

    logic clk = 1'b0, rst_n, tick, bus_wr, wd_rst;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    wdt_keyed #(.CNT_W(16), .DATA_W(32), .RST_CYC(RST_CYC), .REV_CODE(8'h31)) u_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst(wd_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic tick1;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic post(input logic [2:0] a, input logic [31:0] d);
        wr(a, d); tick1();
    endtask

    // Bench model of the key rules (R4, R5, R6): returns {state, armed}
    function automatic logic [2:0] key_model(input logic [1:0] st, input logic arm,
                                             input logic [15:0] w);
        logic [1:0] ns; logic na;
        na = arm;
        if (st == 2'd1 && w == 16'h4444) na = 1'b1;
        if (st == 2'd2 && w == 16'h5555) na = 1'b0;
        ns = (w == 16'hBBBB) ? 2'd1 : (w == 16'hAAAA) ? 2'd2 : 2'd0;
        return {ns, na};
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] d, a, b, pat;
        logic [1:0] ks;
        logic arm;
        logic [2:0] m;
        int w;
        rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);

        // R11 reset state
        rd(AD_STAT, d); chk("R11 status", d, 0);
        rd(AD_CNT, d);  chk("R11 count", d, 0);
        rd(AD_CTRL, d); chk("R11 ctrl", d, 0);
        chk("R11 wd_rst", {31'd0, wd_rst}, 0);
        tick1(); rd(AD_CNT, d); chk("R11 disarmed", d, 0);
        // R1 revision
        rd(AD_REV, d); chk("R1 rev", d, 32'h31);

        // R2 / R3 control pending and dropped second write
        wr(AD_CTRL, 32'h24); rd(AD_STAT, d); chk("R2 ctrl pend", d, 32'h01);
        wr(AD_CTRL, 32'h3C); tick1();
        rd(AD_STAT, d); chk("R2 ctrl clear", d, 0);
        rd(AD_CTRL, d); chk("R3 ignored", d, 32'h24);
        post(AD_CTRL, 32'h0);

        // R2 load pending, R9 load alone leaves count
        wr(AD_LOAD, 32'h100); rd(AD_STAT, d); chk("R2 load pend", d, 32'h04);
        tick1(); rd(AD_LOAD, d); chk("R2 load applied", d, 32'h100);
        rd(AD_CNT, d); chk("R9 no reload", d, 0);

        // R2 / R8 trigger pending and reload
        pat = 32'h1234;
        wr(AD_TRIG, pat); rd(AD_STAT, d); chk("R2 trig pend", d, 32'h08);
        tick1(); rd(AD_CNT, d); chk("R8 reload", d, 32'h100);

        // R2 / R4 key pending and arm
        wr(AD_KEY, 32'hBBBB); rd(AD_STAT, d); chk("R2 key pend", d, 32'h10);
        tick1(); post(AD_KEY, 32'h4444);
        rd(AD_CNT, d); chk("R4 armed start", d, 32'h100);
        repeat (3) tick1();
        rd(AD_CNT, d); chk("R4 counting", d, 32'h103);

        // R8 repeated trigger value does not reload
        post(AD_TRIG, pat); rd(AD_CNT, d); chk("R8 same value", d, 32'h104);
        // R9 new load used at next reload only
        post(AD_LOAD, 32'h200); rd(AD_CNT, d); chk("R9 load pending use", d, 32'h105);
        pat = ~pat; post(AD_TRIG, pat); rd(AD_CNT, d); chk("R9 reload new", d, 32'h200);

        // R5 disarm
        post(AD_KEY, 32'hAAAA); post(AD_KEY, 32'h5555);
        rd(AD_CNT, d); chk("R5 last step", d, 32'h202);
        tick1(); tick1(); rd(AD_CNT, d); chk("R5 frozen", d, 32'h202);

        // R6 broken sequence
        post(AD_KEY, 32'hBBBB); post(AD_KEY, 32'h1234); post(AD_KEY, 32'h4444);
        rd(AD_CNT, a); tick1(); rd(AD_CNT, b); chk("R6 broken", {31'd0, a != b}, 0);

        // R4 R5 R6 random key words against the model
        void'($urandom(32'd2024));
        ks = 2'd0; arm = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] kw;
            case ($urandom_range(0, 5))
                0, 5:    kw = 16'hBBBB;
                1:       kw = 16'h4444;
                2:       kw = 16'hAAAA;
                3:       kw = 16'h5555;
                default: kw = 16'($urandom);
            endcase
            post(AD_KEY, {16'd0, kw});
            m = key_model(ks, arm, kw); ks = m[2:1]; arm = m[0];
            rd(AD_CNT, a); tick1(); rd(AD_CNT, b);
            chk("R6 random key (R4/R5)", {31'd0, a != b}, {31'd0, arm});
        end

        // R7 prescaler, random and directed settings
        post(AD_KEY, 32'hBBBB); post(AD_KEY, 32'h4444);
        for (int i = 0; i < 8; i++) begin
            int p, en, period;
            p  = (i == 0) ? 7 : $urandom_range(0, 7);
            en = (i == 1) ? 0 : (i == 0) ? 1 : $urandom_range(0, 1);
            period = en ? (1 << p) : 1;
            post(AD_CTRL, 32'((en << 5) | (p << 2)));
            pat = ~pat; post(AD_TRIG, pat);
            rd(AD_CNT, d); chk("R7 reload", d, 32'h200);
            repeat (period - 1) tick1();
            rd(AD_CNT, d); chk("R7 before edge", d, 32'h200);
            tick1(); rd(AD_CNT, d); chk("R7 advance", d, 32'h201);
        end

        // R10 overflow
        post(AD_CTRL, 32'h0); post(AD_LOAD, 32'hFFFD);
        pat = ~pat; post(AD_TRIG, pat);
        rd(AD_CNT, d); chk("R10 preload", d, 32'hFFFD);
        tick1(); tick1(); rd(AD_CNT, d); chk("R10 all ones", d, 32'hFFFF);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R10 pulse start", {31'd0, wd_rst}, 1);
        w = 0;
        while (wd_rst === 1'b1 && w < 1000) begin w++; @(negedge clk); end
        chk("R10 pulse width", w, RST_CYC);
        rd(AD_CNT, d); chk("R10 wrapped", d, 0);
        tick1(); rd(AD_CNT, d); chk("R10 disarmed", d, 0);

        // R6 restart: first word after a partial disarm begins arming
        post(AD_KEY, 32'hAAAA); post(AD_KEY, 32'hBBBB); post(AD_KEY, 32'h4444);
        rd(AD_CNT, a); tick1(); rd(AD_CNT, b); chk("R6 restart arms", b, a + 1);

        summary();
    end
endmodule